// File: doc/BRIEF.md
# Serial Frame Receiver with Address-Frame Filter

This block recovers asynchronous character frames from a serial line that rests high. A 16x oversampling tick paces it. The format is set by a handful of static inputs: a character length of five to eight bits, an optional parity bit of selectable kind, an optional ninth "extra" bit carried after the data, and a stop bit. For each frame the block delivers the data, the extra bit and two status flags (parity error and framing error). When the frame passes an acceptance rule, it also gives a single-cycle completion pulse.

The acceptance rule has two settings. In the normal setting, any frame whose stop bit reads 1 is accepted. In the multiprocessor setting, a frame is accepted only if its stop bit reads 1 and its extra bit reads 1 as well. Several nodes on a shared line can then ignore data frames and wake only on address frames. The extra bit is present only when it is enabled in the format, so the multiprocessor setting accepts nothing while the extra bit is disabled.

Top module: `uart_mp_rx`

## Requirements
- R1: After a synchronous reset, `rx_valid`, `par_err`, `frm_err`, `rx_xbit` and `rx_data` are all 0.
- R2: A falling edge on the line begins a start bit, which is taken as real only if the line still reads 0 at the 8th tick after the edge. A low pulse shorter than that produces no frame and no status change.
- R3: `len_sel` encodes the character length as 00=5, 01=6, 10=7, 11=8 bits. Data arrives least significant bit first, and the bits of `rx_data` above the length are 0.
- R4: After the data, the receiver samples the extra bit when `xbit_en`=1, then the parity bit when `par_en`=1, then the stop bit. Each sample falls 16 ticks after the previous one. When `xbit_en`=0, the delivered `rx_xbit` is 0.
- R5: With `par_en`=1, the expected parity bit over the data bits only is selected by `par_sel`: 00 odd, 01 even, 10 always 1, 11 always 0. A mismatch sets `par_err` while the frame is still delivered and accepted. With `par_en`=0, `par_err` is 0.
- R6: Only the first stop bit is sampled. If it reads 0, `frm_err` is set and the frame is not accepted. If it reads 1, `frm_err` is cleared. Both status flags are updated at each stop sample and held until the next one.
- R7: With `mp_en`=0, every frame whose stop bit reads 1 is accepted.
- R8: With `mp_en`=1, a frame is accepted only if its stop bit reads 1 and its extra bit reads 1 with `xbit_en`=1. With `xbit_en`=0, no frame is accepted.
- R9: `rx_valid` is a one-cycle pulse per accepted frame. `rx_data` and `rx_xbit` change only on accepted frames and otherwise hold their previous values.
- R10: The receiver can detect a new start edge immediately after the stop sample, so back-to-back frames with no idle time between them are all received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| len_sel | input | 2 | Character length select |
| par_en | input | 1 | Parity bit present and checked |
| par_sel | input | 2 | Parity kind select |
| xbit_en | input | 1 | Extra bit present after the data |
| mp_en | input | 1 | Multiprocessor acceptance rule |
| rx_data | output | 8 | Received character, upper bits zero |
| rx_xbit | output | 1 | Received extra bit |
| rx_valid | output | 1 | Frame accepted pulse |
| par_err | output | 1 | Parity mismatch on last frame |
| frm_err | output | 1 | Stop bit read 0 on last frame |

## Verification
The frames used vary the character length across all four codes, with data patterns whose upper bits are set so that masking can be seen. All four parity kinds are tried with matching and with deliberately wrong parity bits, which separates the kinds and shows that a bad bit is flagged but still delivered. Address and data frames are sent with the multiprocessor rule on and off, and with the extra bit absent, which separates the two acceptance rules. A broken stop bit, a short glitch and a pair of frames with no idle gap exercise framing errors, start validation and immediate restart.

// File: rtl/rxmp_pkg.sv
package rxmp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_XBIT,
    S_PAR,
    S_STOP
  } rx_state_t;

  localparam logic [1:0] PK_ODD   = 2'b00;
  localparam logic [1:0] PK_EVEN  = 2'b01;
  localparam logic [1:0] PK_ONE   = 2'b10;
  localparam logic [1:0] PK_ZERO  = 2'b11;

  // expected parity bit given the xor of the data bits
  function automatic logic expect_parity(input logic [1:0] kind, input logic dxor);
    logic r;
    case (kind)
      PK_ODD:  r = ~dxor;
      PK_EVEN: r = dxor;
      PK_ONE:  r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rxmp_sync.sv
module rxmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b1;
    else     last <= chain[STAGES-1];
  end

  assign dout = chain[STAGES-1];
  assign fall = last & ~dout;

endmodule

// File: rtl/rxmp_bitclk.sv
module rxmp_bitclk #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  input  logic half,
  output logic strobe
);

  localparam int CW   = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int HALF = OSR / 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim    = half ? CW'(HALF - 1) : CW'(OSR - 1);
  assign strobe = tick & ~hold & (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= strobe ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rxmp_frame.sv
module rxmp_frame
  import rxmp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxs,
  input  logic          fall,
  input  logic          strobe,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic [1:0]    par_sel,
  input  logic          xbit_en,
  input  logic          mp_en,
  output logic          hold,
  output logic          half,
  output logic [DW-1:0] rx_data,
  output logic          rx_xbit,
  output logic          rx_valid,
  output logic          par_err,
  output logic          frm_err
);

  localparam int MIN_LEN = DW - 3;
  localparam int BW      = $clog2(DW);

  rx_state_t     state;
  logic [BW-1:0] bidx;
  logic [BW-1:0] last_idx;
  logic [DW-1:0] shreg;
  logic          pacc;
  logic          xb_r;
  logic          perr_r;
  logic          accept;

  assign last_idx = BW'(MIN_LEN - 1) + BW'(len_sel);
  assign hold     = (state == S_IDLE);
  assign half     = (state == S_START);
  assign accept   = rxs & (~mp_en | (xbit_en & xb_r));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      bidx     <= '0;
      shreg    <= '0;
      pacc     <= 1'b0;
      xb_r     <= 1'b0;
      perr_r   <= 1'b0;
      rx_data  <= '0;
      rx_xbit  <= 1'b0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (fall) state <= S_START;
        end
        S_START: begin
          if (strobe) begin
            if (!rxs) begin
              state  <= S_DATA;
              bidx   <= '0;
              shreg  <= '0;
              pacc   <= 1'b0;
              xb_r   <= 1'b0;
              perr_r <= 1'b0;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_DATA: begin
          if (strobe) begin
            shreg[bidx] <= rxs;
            pacc        <= pacc ^ rxs;
            if (bidx == last_idx) begin
              if (xbit_en)     state <= S_XBIT;
              else if (par_en) state <= S_PAR;
              else             state <= S_STOP;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
        end
        S_XBIT: begin
          if (strobe) begin
            xb_r  <= rxs;
            state <= par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          if (strobe) begin
            perr_r <= (rxs != expect_parity(par_sel, pacc));
            state  <= S_STOP;
          end
        end
        S_STOP: begin
          if (strobe) begin
            frm_err <= ~rxs;
            par_err <= perr_r & par_en;
            if (accept) begin
              rx_valid <= 1'b1;
              rx_data  <= shreg;
              rx_xbit  <= xb_r & xbit_en;
            end
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx #(
  parameter int OSR         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          rxd,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic [1:0]    par_sel,
  input  logic          xbit_en,
  input  logic          mp_en,
  output logic [DW-1:0] rx_data,
  output logic          rx_xbit,
  output logic          rx_valid,
  output logic          par_err,
  output logic          frm_err
);

  logic rxs;
  logic fall;
  logic strobe;
  logic hold;
  logic half;

  rxmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (rxs),
    .fall (fall)
  );

  rxmp_bitclk #(.OSR(OSR)) u_bitclk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick16),
    .hold   (hold),
    .half   (half),
    .strobe (strobe)
  );

  rxmp_frame #(.DW(DW)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .rxs      (rxs),
    .fall     (fall),
    .strobe   (strobe),
    .len_sel  (len_sel),
    .par_en   (par_en),
    .par_sel  (par_sel),
    .xbit_en  (xbit_en),
    .mp_en    (mp_en),
    .hold     (hold),
    .half     (half),
    .rx_data  (rx_data),
    .rx_xbit  (rx_xbit),
    .rx_valid (rx_valid),
    .par_err  (par_err),
    .frm_err  (frm_err)
  );

endmodule

// File: rtl/rxmp_chk.sv
module rxmp_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    len_sel,
  input logic          par_en,
  input logic          xbit_en,
  input logic          mp_en,
  input logic [DW-1:0] rx_data,
  input logic          rx_xbit,
  input logic          rx_valid,
  input logic          par_err,
  input logic          frm_err
);

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_valid_needs_stop_r6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !frm_err);

  p_mp_address_only_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && $past(mp_en)) |-> (rx_xbit && $past(xbit_en)));

  p_len_mask_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> (4'd5 + 4'($past(len_sel)))) == '0));

  p_par_off_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !$past(par_en)) |-> !par_err);

  p_xbit_absent_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !$past(xbit_en)) |-> !rx_xbit);

endmodule

bind uart_mp_rx rxmp_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .len_sel  (len_sel),
  .par_en   (par_en),
  .xbit_en  (xbit_en),
  .mp_en    (mp_en),
  .rx_data  (rx_data),
  .rx_xbit  (rx_xbit),
  .rx_valid (rx_valid),
  .par_err  (par_err),
  .frm_err  (frm_err)
);

// File: tb/tb_uart_mp_rx.sv
module tb_uart_mp_rx;

  localparam int TDIV = 4;
  localparam int BITCLK = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] len_sel = 2'b11;
  logic       par_en = 1'b0;
  logic [1:0] par_sel = 2'b00;
  logic       xbit_en = 1'b0;
  logic       mp_en = 1'b0;
  logic [7:0] rx_data;
  logic       rx_xbit, rx_valid, par_err, frm_err;

  uart_mp_rx dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
    .len_sel(len_sel), .par_en(par_en), .par_sel(par_sel),
    .xbit_en(xbit_en), .mp_en(mp_en),
    .rx_data(rx_data), .rx_xbit(rx_xbit), .rx_valid(rx_valid),
    .par_err(par_err), .frm_err(frm_err)
  );

  always #5 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv   = (tdiv + 1) % TDIV;
    tick16 = (tdiv == 0);
  end

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  logic [8:0] expq[$];
  logic [7:0] mdl_data = 8'h00;
  logic       mdl_xbit = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
    end
  endtask

  // compare on every clock: any pulse must match the head of the model queue
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected rx_valid", 1, 0);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        check(rx_data == e[7:0], "R3 rx_data on pulse", rx_data, e[7:0]);
        check(rx_xbit == e[8], "R4 rx_xbit on pulse", rx_xbit, e[8]);
      end
    end
  end

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int len, input bit pe,
                            input logic [1:0] pk, input bit xe, input bit xb,
                            input bit stopv, input bit mp, input bit flip,
                            input int idle_bits, input string tag);
    logic [7:0] dm;
    logic       p;
    bit         acc;
    @(negedge clk);
    len_sel = 2'(len - 5);
    par_en  = pe;
    par_sel = pk;
    xbit_en = xe;
    mp_en   = mp;
    dm = d & 8'((1 << len) - 1);
    case (pk)
      2'b00:   p = ~(^dm);
      2'b01:   p = ^dm;
      2'b10:   p = 1'b1;
      default: p = 1'b0;
    endcase
    if (flip) p = ~p;
    acc = stopv && (!mp || (xe && xb));
    if (acc) begin
      mdl_data = dm;
      mdl_xbit = xe & xb;
      expq.push_back({mdl_xbit, mdl_data});
    end
    send_bit(1'b0);
    for (int i = 0; i < len; i++) send_bit(dm[i]);
    if (xe) send_bit(xb);
    if (pe) send_bit(p);
    send_bit(stopv);
    for (int i = 0; i < idle_bits; i++) send_bit(1'b1);
    check(expq.size() == 0, {tag, " accept count"}, expq.size(), 0);
    check(frm_err == !stopv, {"R6 frm_err ", tag}, frm_err, !stopv);
    check(par_err == (pe && flip), {"R5 par_err ", tag}, par_err, pe && flip);
    check(rx_data == mdl_data, {"R9 rx_data held/updated ", tag}, rx_data, mdl_data);
    check(rx_xbit == mdl_xbit, {"R9 rx_xbit held/updated ", tag}, rx_xbit, mdl_xbit);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(rx_valid == 0 && par_err == 0 && frm_err == 0 && rx_xbit == 0 && rx_data == 0,
          "R1 reset state", {rx_data, rx_valid, par_err, frm_err, rx_xbit}, 0);

    // R7 plain 8-bit frame
    send_frame(8'hA5, 8, 0, 2'b00, 0, 0, 1, 0, 0, 1, "R7 8bit");
    // R3 each length, upper bits masked
    send_frame(8'hFF, 5, 0, 2'b00, 0, 0, 1, 0, 0, 1, "R3 len5");
    send_frame(8'hEA, 6, 0, 2'b00, 0, 0, 1, 0, 0, 1, "R3 len6");
    send_frame(8'hD3, 7, 0, 2'b00, 0, 0, 1, 0, 0, 1, "R3 len7");
    // R5 each parity kind, correct then wrong
    send_frame(8'h3C, 8, 1, 2'b00, 0, 0, 1, 0, 0, 1, "R5 odd ok");
    send_frame(8'h3D, 8, 1, 2'b00, 0, 0, 1, 0, 1, 1, "R5 odd bad");
    send_frame(8'h17, 7, 1, 2'b01, 0, 0, 1, 0, 0, 1, "R5 even ok");
    send_frame(8'h16, 6, 1, 2'b01, 0, 0, 1, 0, 1, 1, "R5 even bad");
    send_frame(8'h55, 8, 1, 2'b10, 0, 0, 1, 0, 0, 1, "R5 mark ok");
    send_frame(8'h55, 8, 1, 2'b10, 0, 0, 1, 0, 1, 1, "R5 mark bad");
    send_frame(8'h0F, 5, 1, 2'b11, 0, 0, 1, 0, 0, 1, "R5 space ok");
    send_frame(8'h0F, 5, 1, 2'b11, 0, 0, 1, 0, 1, 1, "R5 space bad");
    // R6 broken stop bit, then recovery clears flag
    send_frame(8'h81, 8, 0, 2'b00, 0, 0, 0, 0, 0, 2, "R6 bad stop");
    send_frame(8'h42, 8, 0, 2'b00, 0, 0, 1, 0, 0, 1, "R6 recover");
    // R4 extra bit and parity ordering, mp off accepts either value
    send_frame(8'h9C, 8, 1, 2'b01, 1, 0, 1, 0, 0, 1, "R4 xbit0 par");
    send_frame(8'h63, 8, 1, 2'b00, 1, 1, 1, 0, 0, 1, "R4 xbit1 par");
    // R8 multiprocessor rule
    send_frame(8'h11, 8, 0, 2'b00, 1, 0, 1, 1, 0, 1, "R8 data frame rejected");
    send_frame(8'h22, 8, 0, 2'b00, 1, 1, 1, 1, 0, 1, "R8 address accepted");
    send_frame(8'h33, 8, 0, 2'b00, 0, 0, 1, 1, 0, 1, "R8 no xbit rejected");
    send_frame(8'h44, 8, 1, 2'b10, 1, 1, 0, 1, 0, 2, "R8 address bad stop");

    // R2 short glitch
    @(negedge clk);
    mp_en = 1'b0; xbit_en = 1'b0; par_en = 1'b0; len_sel = 2'b11;
    rxd = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    check(expq.size() == 0, "R2 glitch no frame", expq.size(), 0);
    check(rx_data == mdl_data, "R2 glitch data unchanged", rx_data, mdl_data);
    send_frame(8'h5A, 8, 0, 2'b00, 0, 0, 1, 0, 0, 1, "R2 after glitch");

    // R10 back-to-back frames, no idle gap
    send_frame(8'hC3, 8, 0, 2'b00, 0, 0, 1, 0, 0, 0, "R10 first");
    send_frame(8'h3E, 8, 1, 2'b01, 0, 0, 1, 0, 0, 0, "R10 second");
    send_frame(8'h07, 5, 0, 2'b00, 0, 0, 1, 0, 0, 1, "R10 third");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule